// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sits between a processor core and the clock tree and decides which clocks run. A one-cycle sleep request from the core sends the controller into one of two low-power states. With the stored idle-enable bit clear, it enters full sleep: every device clock is gated off, the selected oscillator stops, and the clock-source status is cleared. With the bit set, it enters idle: only the core clock is gated, peripherals keep running from the selected source, and the status is kept.

Only an interrupt, a watchdog time-out or a reset brings the controller back to run. Leaving sleep on the primary source waits for an oscillator start-up count, and then for a PLL lock count when PLL operation is strapped on. If two-speed start-up or the fail-safe monitor is enabled, the device runs early from the internal oscillator during that wait. Leaving idle holds only the core clock for a fixed core-start delay. The two wait lengths and the start-up count are parameters, so a bench can use short values. The stored idle-enable bit and source select are written only by the core and never by a wake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, idle_en_q=0, clk_sel_q=00, cpu_clk_en=0, per_clk_en=0, osc_ready=0 and clk_sts=000. After release, with no fallback and no PLL, cpu_clk_en first reads 1 after OST_CYCLES rising edges.
- R2: A sleep request in run with idle_en_q=0 and no wake leads, on the next edge, to cpu_clk_en=0, per_clk_en=0, pri_osc_en=0, int_osc_en=0, clk_sts=000 and osc_ready=0.
- R3: A sleep request in run with idle_en_q=1 and no wake leads, on the next edge, to cpu_clk_en=0 and per_clk_en=1. clk_sts and osc_ready are unchanged. The oscillator of the selected source stays enabled: 00 is primary, 01 is the secondary oscillator, and 1x is the internal oscillator.
- R4: In sleep or idle, further sleep requests have no effect; only irq_wake or wdt_wake leaves.
- R5: Take the edge that samples a wake from sleep as edge 1, with clk_sel_q=00 and no fallback. cpu_clk_en first reads 1 after edge OST_CYCLES+1, or after edge OST_CYCLES+PLL_CYCLES+1 when pll_mode=1. From then on, clk_sts=001 (bit0 primary, bit1 secondary, bit2 internal) and osc_ready=1.
- R6: With two_speed_en or fscm_en high, the same wake turns both clocks on after edge 1, with clk_sts=100 and osc_ready=0. Once the primary wait ends, the controller reports clk_sts=001 and osc_ready=1.
- R7: No wake changes idle_en_q or clk_sel_q; they change only on a cfg_we cycle.
- R8: On wake from idle, per_clk_en stays 1 and cpu_clk_en first reads 1 after edge CSD_CYCLES+1. clk_sts and osc_ready keep their idle values.
- R9: lfrc_en follows wdt_en, and sec_osc_en follows t1osc_en, during sleep.
- R10: A wake in the same cycle as a sleep request cancels the entry, and the controller stays in run.
- R11: On wake from sleep with clk_sel_q other than 00, both clocks first read 1 after edge CSD_CYCLES+1. clk_sts is then 010 for select 01 and 100 for select 1x, and osc_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the reset wake |
| sleep_req | input | 1 | One-cycle request from the sleep instruction |
| irq_wake | input | 1 | Interrupt wake event |
| wdt_wake | input | 1 | Watchdog time-out wake event |
| cfg_we | input | 1 | Write strobe for the mode bits |
| cfg_idle_en | input | 1 | Idle-enable value to store |
| cfg_clk_sel | input | 2 | Clock-source select to store |
| pll_mode | input | 1 | Primary source runs through the PLL |
| two_speed_en | input | 1 | Two-speed start-up enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| wdt_en | input | 1 | Watchdog enabled |
| t1osc_en | input | 1 | Secondary timer oscillator enabled |
| idle_en_q | output | 1 | Stored idle-enable bit |
| clk_sel_q | output | 2 | Stored clock-source select |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| int_osc_en | output | 1 | Internal oscillator block enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| lfrc_en | output | 1 | Internal low-frequency oscillator enable |
| clk_sts | output | 3 | Clock-source status, one-hot or zero |
| osc_ready | output | 1 | Primary source is clocking the device |

## Verification
The sleep and idle entry results appear one edge after the request, so they are sampled on the following falling edge. For every wake, the bench drives the event on a falling edge and counts rising edges until cpu_clk_en reads 1. It compares that count against OST_CYCLES+1, OST_CYCLES+PLL_CYCLES+1, CSD_CYCLES+1, or 1 for fallback. It reads clk_sts and osc_ready at the same falling edge. After a fallback wake it waits well past the primary wait before it checks the final status.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [2:0] {
      ST_RUN, ST_SLEEP, ST_IDLE, ST_OST, ST_PLL, ST_SRC, ST_CSD
   } pmc_state_e;

   localparam logic [1:0] SEL_PRI = 2'b00;
   localparam logic [1:0] SEL_SEC = 2'b01;

   function automatic logic [2:0] src_onehot(input logic [1:0] sel);
      if (sel[1])      return 3'b100;
      else if (sel[0]) return 3'b010;
      else             return 3'b001;
   endfunction
endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             idle_d,
   input  logic [SEL_W-1:0] sel_d,
   output logic             idle_q,
   output logic [SEL_W-1:0] sel_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= 1'b0;
         sel_q  <= '0;
      end else if (we) begin
         idle_q <= idle_d;
         sel_q  <= sel_d;
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(idle_q) && $stable(sel_q))); // R7
endmodule

// File: rtl/pmc_delay_cnt.sv
module pmc_delay_cnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] limit,
   output logic          done
);
   logic [CW-1:0] cnt;

   assign done = (cnt == limit - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (!done) cnt <= cnt + CW'(1);
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt < limit)); // R5
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int OST_CYCLES  = 1024,
   parameter int PLL_CYCLES  = 4096,
   parameter int CSD_CYCLES  = 16,
   parameter bit HAS_PLL     = 1'b1,
   parameter bit FALLBACK_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       irq_wake,
   input  logic       wdt_wake,
   input  logic       cfg_we,
   input  logic       cfg_idle_en,
   input  logic [1:0] cfg_clk_sel,
   input  logic       pll_mode,
   input  logic       two_speed_en,
   input  logic       fscm_en,
   input  logic       wdt_en,
   input  logic       t1osc_en,
   output logic       idle_en_q,
   output logic [1:0] clk_sel_q,
   output logic       cpu_clk_en,
   output logic       per_clk_en,
   output logic       pri_osc_en,
   output logic       int_osc_en,
   output logic       sec_osc_en,
   output logic       lfrc_en,
   output logic [2:0] clk_sts,
   output logic       osc_ready
);
   localparam int MAX_A = (OST_CYCLES > PLL_CYCLES) ? OST_CYCLES : PLL_CYCLES;
   localparam int MAX_C = (MAX_A > CSD_CYCLES) ? MAX_A : CSD_CYCLES;
   localparam int CW    = $clog2(MAX_C + 1);

   if (OST_CYCLES < 1) begin : g_bad_ost
      $error("OST_CYCLES must be at least 1");
   end
   if (PLL_CYCLES < 1) begin : g_bad_pll
      $error("PLL_CYCLES must be at least 1");
   end
   if (CSD_CYCLES < 1) begin : g_bad_csd
      $error("CSD_CYCLES must be at least 1");
   end

   logic pll_on, fb_on;
   if (HAS_PLL) begin : g_pll
      assign pll_on = pll_mode;
   end else begin : g_no_pll
      assign pll_on = 1'b0;
   end
   if (FALLBACK_EN) begin : g_fb
      assign fb_on = two_speed_en | fscm_en;
   end else begin : g_no_fb
      assign fb_on = 1'b0;
   end

   pmc_state_e    state, nxt;
   logic          wake, done, clr, pri_wait;
   logic [CW-1:0] limit;

   assign wake     = irq_wake | wdt_wake;
   assign pri_wait = (state == ST_OST) || (state == ST_PLL);

   pmc_cfg_reg #(.SEL_W(2)) i_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idle_d(cfg_idle_en),
      .sel_d(cfg_clk_sel), .idle_q(idle_en_q), .sel_q(clk_sel_q)
   );

   always_comb begin
      case (state)
         ST_OST:  limit = CW'(OST_CYCLES);
         ST_PLL:  limit = CW'(PLL_CYCLES);
         default: limit = CW'(CSD_CYCLES);
      endcase
   end

   assign clr = (nxt != state) || (state == ST_RUN) ||
                (state == ST_SLEEP) || (state == ST_IDLE);

   pmc_delay_cnt #(.CW(CW)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .limit(limit), .done(done)
   );

   always_comb begin
      nxt = state;
      case (state)
         ST_RUN:   if (sleep_req && !wake) nxt = idle_en_q ? ST_IDLE : ST_SLEEP;
         ST_SLEEP: if (wake) nxt = (clk_sel_q == SEL_PRI) ? ST_OST : ST_SRC;
         ST_IDLE:  if (wake) nxt = ST_CSD;
         ST_OST:   if (done) nxt = pll_on ? ST_PLL : ST_RUN;
         ST_PLL:   if (done) nxt = ST_RUN;
         ST_SRC:   if (done) nxt = ST_RUN;
         ST_CSD:   if (done) nxt = ST_RUN;
         default:  nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_OST;
         clk_sts   <= 3'b000;
         osc_ready <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_RUN && nxt == ST_SLEEP) begin
            clk_sts   <= 3'b000;
            osc_ready <= 1'b0;
         end else if (pri_wait && nxt == ST_RUN) begin
            clk_sts   <= 3'b001;
            osc_ready <= 1'b1;
         end else if (nxt == ST_OST || nxt == ST_PLL) begin
            clk_sts   <= fb_on ? 3'b100 : 3'b000;
         end else if (state == ST_SRC && nxt == ST_RUN) begin
            clk_sts   <= src_onehot(clk_sel_q);
         end
      end
   end

   always_comb begin
      cpu_clk_en = 1'b0;
      per_clk_en = 1'b0;
      case (state)
         ST_RUN:          begin cpu_clk_en = 1'b1;  per_clk_en = 1'b1;  end
         ST_IDLE, ST_CSD: begin cpu_clk_en = 1'b0;  per_clk_en = 1'b1;  end
         ST_OST, ST_PLL:  begin cpu_clk_en = fb_on; per_clk_en = fb_on; end
         default:         begin cpu_clk_en = 1'b0;  per_clk_en = 1'b0;  end
      endcase
   end

   assign pri_osc_en = pri_wait || (state != ST_SLEEP && clk_sel_q == SEL_PRI);
   assign int_osc_en = (state != ST_SLEEP && clk_sel_q[1]) || (pri_wait && fb_on);
   assign sec_osc_en = t1osc_en || (state != ST_SLEEP && clk_sel_q == SEL_SEC);
   assign lfrc_en    = wdt_en || int_osc_en;

   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_req && !wake && !idle_en_q) |=>
      (!cpu_clk_en && !per_clk_en && !pri_osc_en && clk_sts == 3'b000 && !osc_ready)); // R2
   AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_req && !wake && idle_en_q) |=>
      (!cpu_clk_en && per_clk_en && $stable(clk_sts) && $stable(osc_ready))); // R3
   AST_ONLY_WAKE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_SLEEP || state == ST_IDLE) && !wake) |=> $stable(state)); // R4
   AST_ABORT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_req && wake) |=> cpu_clk_en); // R10
   AST_READY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_ready) |-> (clk_sts == 3'b001 && cpu_clk_en)); // R5
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
   localparam int OST = 8;
   localparam int PLL = 5;
   localparam int CSD = 3;
   localparam int NV  = 10;

   // {idle, sel[2], pll, fb{fscm,two}[2], src(0 irq,1 wdt), exp_edges[5], exp_sts[3], exp_ready}
   localparam logic [15:0] VEC [NV] = '{
      {1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 5'd9,  3'b001, 1'b1},
      {1'b0, 2'b00, 1'b1, 2'b00, 1'b1, 5'd14, 3'b001, 1'b1},
      {1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 5'd4,  3'b001, 1'b1},
      {1'b0, 2'b01, 1'b0, 2'b00, 1'b1, 5'd4,  3'b010, 1'b0},
      {1'b1, 2'b01, 1'b0, 2'b00, 1'b0, 5'd4,  3'b010, 1'b0},
      {1'b0, 2'b10, 1'b0, 2'b00, 1'b0, 5'd4,  3'b100, 1'b0},
      {1'b0, 2'b11, 1'b0, 2'b00, 1'b1, 5'd4,  3'b100, 1'b0},
      {1'b1, 2'b11, 1'b0, 2'b00, 1'b1, 5'd4,  3'b100, 1'b0},
      {1'b0, 2'b00, 1'b0, 2'b01, 1'b0, 5'd1,  3'b100, 1'b0},
      {1'b0, 2'b00, 1'b1, 2'b10, 1'b1, 5'd1,  3'b100, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic sleep_req = 0, irq_wake = 0, wdt_wake = 0, cfg_we = 0, cfg_idle_en = 0;
   logic [1:0] cfg_clk_sel = 2'b00;
   logic pll_mode = 0, two_speed_en = 0, fscm_en = 0, wdt_en = 0, t1osc_en = 0;
   logic idle_en_q, cpu_clk_en, per_clk_en, pri_osc_en, int_osc_en, sec_osc_en, lfrc_en, osc_ready;
   logic [1:0] clk_sel_q;
   logic [2:0] clk_sts;
   int checks = 0, fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   pwr_mode_ctrl #(.OST_CYCLES(OST), .PLL_CYCLES(PLL), .CSD_CYCLES(CSD)) i_pwr_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_wake(irq_wake),
      .wdt_wake(wdt_wake), .cfg_we(cfg_we), .cfg_idle_en(cfg_idle_en),
      .cfg_clk_sel(cfg_clk_sel), .pll_mode(pll_mode), .two_speed_en(two_speed_en),
      .fscm_en(fscm_en), .wdt_en(wdt_en), .t1osc_en(t1osc_en), .idle_en_q(idle_en_q),
      .clk_sel_q(clk_sel_q), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .pri_osc_en(pri_osc_en), .int_osc_en(int_osc_en), .sec_osc_en(sec_osc_en),
      .lfrc_en(lfrc_en), .clk_sts(clk_sts), .osc_ready(osc_ready)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_to_cpu(output int n, output bit per_drop);
      n = 0; per_drop = 0;
      while (n < 60) begin
         @(posedge clk); n++;
         @(negedge clk); irq_wake = 0; wdt_wake = 0;
         if (cpu_clk_en) break;
         if (!per_clk_en) per_drop = 1;
      end
   endtask

   task automatic do_cfg(input logic idle, input logic [1:0] sel);
      @(negedge clk); cfg_we = 1; cfg_idle_en = idle; cfg_clk_sel = sel;
      @(negedge clk); cfg_we = 0;
   endtask

   initial begin
      int n;
      bit drop;
      // reset state, R1
      repeat (3) @(negedge clk);
      chk("R1 cpu_clk_en in reset", int'(cpu_clk_en), 0);
      chk("R1 per_clk_en in reset", int'(per_clk_en), 0);
      chk("R1 idle_en_q in reset", int'(idle_en_q), 0);
      chk("R1 clk_sel_q in reset", int'(clk_sel_q), 0);
      chk("R1 status in reset", int'({clk_sts, osc_ready}), 0);
      rst_n = 1;
      count_to_cpu(n, drop);
      chk("R1 edges to run after reset", n, OST);
      chk("R1 status after start-up", int'({clk_sts, osc_ready}), 4'b0011);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         logic idle, pll, src, rdy;
         logic [1:0] sel, fb;
         logic [2:0] sts;
         int exp_n;
         string tag;
         v = VEC[i];
         {idle, sel, pll, fb, src} = v[15:9];
         exp_n = int'(v[8:4]); sts = v[3:1]; rdy = v[0];
         tag = idle ? "R8" : (fb != 0) ? "R6" : (sel != 0) ? "R11" : "R5";
         pll_mode = pll; two_speed_en = fb[0]; fscm_en = fb[1];
         do_cfg(idle, sel);
         @(negedge clk); sleep_req = 1;
         @(negedge clk); sleep_req = 0;
         chk(idle ? "R3 cpu off in idle" : "R2 cpu off in sleep", int'(cpu_clk_en), 0);
         chk(idle ? "R3 per on in idle" : "R2 per off in sleep", int'(per_clk_en), int'(idle));
         if (!idle) begin
            chk("R2 oscillators stopped", int'({pri_osc_en, int_osc_en, sec_osc_en}), 0);
            chk("R2 status cleared", int'({clk_sts, osc_ready}), 0);
         end else begin
            chk("R3 selected oscillator kept",
                int'(sel == 2'b00 ? pri_osc_en : sel == 2'b01 ? sec_osc_en : int_osc_en), 1);
         end
         @(negedge clk); sleep_req = 1;
         @(negedge clk); sleep_req = 0;
         @(negedge clk);
         chk("R4 repeated request ignored", int'({cpu_clk_en, per_clk_en}), int'({1'b0, idle}));
         if (src) wdt_wake = 1; else irq_wake = 1;
         count_to_cpu(n, drop);
         chk({tag, " edges from wake to core clock"}, n, exp_n);
         chk({tag, " status at core clock"}, int'({clk_sts, osc_ready}), int'({sts, rdy}));
         chk({tag, " peripheral clock on at core clock"}, int'(per_clk_en), 1);
         if (idle) chk("R8 peripheral clock held through wake", int'(drop), 0);
         chk("R7 mode bits kept across wake", int'({idle_en_q, clk_sel_q}), int'({idle, sel}));
         repeat (20) @(negedge clk);
         if (fb != 0) chk("R6 primary takes over after wait", int'({clk_sts, osc_ready}), 4'b0011);
      end

      // R10: wake with the request cancels entry
      two_speed_en = 0; fscm_en = 0; pll_mode = 0;
      do_cfg(1'b0, 2'b00);
      @(negedge clk); sleep_req = 1; irq_wake = 1;
      @(negedge clk); sleep_req = 0; irq_wake = 0;
      chk("R10 stays in run", int'({cpu_clk_en, per_clk_en}), 3);
      repeat (2) @(negedge clk);
      chk("R10 still in run", int'(cpu_clk_en), 1);

      // R9: keep-alive oscillators in sleep
      wdt_en = 1; t1osc_en = 1;
      @(negedge clk); sleep_req = 1;
      @(negedge clk); sleep_req = 0;
      chk("R9 watchdog oscillator on in sleep", int'(lfrc_en), 1);
      chk("R9 secondary oscillator on in sleep", int'(sec_osc_en), 1);
      wdt_en = 0; t1osc_en = 0;
      @(negedge clk);
      chk("R9 watchdog oscillator off in sleep", int'(lfrc_en), 0);
      chk("R9 secondary oscillator off in sleep", int'(sec_osc_en), 0);
      wdt_wake = 1;
      count_to_cpu(n, drop);
      chk("R5 watchdog wake edges", n, OST + 1);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         fails++; checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule